// File: doc/BRIEF.md
# Thread-Indexed Section State Store

This block holds the per-thread state of a datapath that has been C-slowed into several pipeline stages. The registers that used to hold one copy of the state are replaced by memories of THREADS entries, one entry per thread context. A result returning from the pipeline is written at the entry named by its thread index. A separate scheduler, outside this block, picks which thread enters next and can pick any stored thread.

The state word is split into SECTIONS slices, each kept in its own memory section. Section k feeds pipeline stage k. Each section is read with the scheduler's read index delayed by k clocks through a chain on the address, so no data shift registers are needed between the memories and the stages. A per-section write enable lets part of a context be kept, so no hold multiplexer is needed in the feedback path.

After reset a sequential clear walks through every context and writes zero to all sections. The store accepts reads and writes only once that walk has finished.

Top module: `hps_state_store`

## Requirements
- R1: After reset is released, `ready` stays low for exactly THREADS clock cycles while the contexts are cleared. It then goes high and stays high until the next reset.
- R2: Once `ready` is high after a reset, every section of every context reads as zero until it is written.
- R3: A read accepted in cycle t for thread i makes `out_valid[k]` high in cycle t+k+1. In that same cycle, `out_tid` slice k equals i and `out_data` slice k (bits k*WIDTH upward) holds the stored section-k state of thread i.
- R4: A write with `wr_valid` high and `wr_en[k]` high stores `wr_data` slice k at entry `wr_tid` of section k.
- R5: A write with `wr_en[k]` low leaves section k of that thread unchanged, while the enabled sections are updated.
- R6: If a section reads and writes the same entry on the same clock edge, it returns the data held before the write. Sections that read that entry on later edges return the new data.
- R7: While `ready` is low, `rd_valid` and `wr_valid` are ignored. No output valid is raised and no context is changed.
- R8: Reads may be issued back to back, one per cycle, for any thread indices below THREADS and in any order. Each read returns its own thread's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear walk |
| ready | output | 1 | High once all contexts have been cleared |
| rd_valid | input | 1 | Scheduler issues a thread into the pipeline |
| rd_tid | input | AW | Thread index to read |
| wr_valid | input | 1 | A pipeline result is returning |
| wr_tid | input | AW | Thread index of the returning result |
| wr_en | input | SECTIONS | Per-section write enable; a low bit keeps that section |
| wr_data | input | SECTIONS*WIDTH | Returning state, section k in bits k*WIDTH upward |
| out_valid | output | SECTIONS | Section k output carries a thread's state |
| out_tid | output | SECTIONS*AW | Thread index shown by each section |
| out_data | output | SECTIONS*WIDTH | Registered state slice for each pipeline stage |

## Verification
On every cycle, the assertions check the following: `ready` stays high once it has risen; the address chain moves each issued read one stage per clock with its index unchanged; no output valid appears before the clear walk is done; and read and write indices stay below THREADS. The data path can only be shown by the bench scenarios. These cover the zero contents after clearing, the one-cycle-per-section skew of the returned slices, partial writes that keep masked sections, and the old-data result when a read and a write hit the same entry on the same edge. They also cover ignoring traffic during the clear and random back-to-back read orders checked against a per-thread model.

// File: rtl/hps_pkg.sv
package hps_pkg;

  // Width of a thread index for a given number of contexts (at least one bit).
  function automatic int tid_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hps_clear_ctrl.sv
module hps_clear_ctrl #(
  parameter int DEPTH = 6,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  output logic          clearing,
  output logic [AW-1:0] clr_addr,
  output logic          ready
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_addr <= '0;
      ready    <= 1'b0;
    end else if (clearing) begin
      if (clr_addr == LAST) begin
        clearing <= 1'b0;
        ready    <= 1'b1;
      end else begin
        clr_addr <= clr_addr + 1'b1;
      end
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1

  AST_CLEAR_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    clearing |-> !ready); // R1

endmodule

// File: rtl/hps_addr_chain.sv
module hps_addr_chain #(
  parameter int STAGES = 3,
  parameter int AW     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [AW-1:0]              in_tid,
  output logic [STAGES-1:0]          tap_valid,
  output logic [STAGES-1:0][AW-1:0]  tap_tid
);

  // tap k carries the read issued k+1 cycles earlier.
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_valid <= '0;
      tap_tid   <= '0;
    end else begin
      tap_valid[0] <= in_valid;
      tap_tid[0]   <= in_tid;
      for (int k = 1; k < STAGES; k++) begin
        tap_valid[k] <= tap_valid[k-1];
        tap_tid[k]   <= tap_tid[k-1];
      end
    end
  end

  AST_TAP0_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    tap_valid[0] |-> $past(in_valid)); // R3

  for (genvar g = 1; g < STAGES; g++) begin : g_chk
    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
      tap_valid[g] |-> ($past(tap_valid[g-1]) && tap_tid[g] == $past(tap_tid[g-1]))); // R3
  end

endmodule

// File: rtl/hps_mem_section.sv
module hps_mem_section #(
  parameter int DEPTH = 6,
  parameter int AW    = 3,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Read-first single-clock RAM: a same-edge write is not seen by the read.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH)); // R4

endmodule

// File: rtl/hps_state_store.sv
module hps_state_store import hps_pkg::*; #(
  parameter  int THREADS  = 6,
  parameter  int SECTIONS = 3,
  parameter  int WIDTH    = 8,
  localparam int AW       = tid_bits(THREADS)
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic                      ready,
  input  logic                      rd_valid,
  input  logic [AW-1:0]             rd_tid,
  input  logic                      wr_valid,
  input  logic [AW-1:0]             wr_tid,
  input  logic [SECTIONS-1:0]       wr_en,
  input  logic [SECTIONS*WIDTH-1:0] wr_data,
  output logic [SECTIONS-1:0]       out_valid,
  output logic [SECTIONS*AW-1:0]    out_tid,
  output logic [SECTIONS*WIDTH-1:0] out_data
);

  logic                          clearing;
  logic [AW-1:0]                 clr_addr;
  logic                          rd_go;
  logic [SECTIONS-1:0]           tap_valid;
  logic [SECTIONS-1:0][AW-1:0]   tap_tid;

  hps_clear_ctrl #(.DEPTH(THREADS), .AW(AW)) u_clear (
    .clk      (clk),
    .rst      (rst),
    .clearing (clearing),
    .clr_addr (clr_addr),
    .ready    (ready)
  );

  assign rd_go = rd_valid & ready;

  hps_addr_chain #(.STAGES(SECTIONS), .AW(AW)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_go),
    .in_tid    (rd_tid),
    .tap_valid (tap_valid),
    .tap_tid   (tap_tid)
  );

  assign out_valid = tap_valid;

  for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
    logic             we;
    logic [AW-1:0]    waddr;
    logic [WIDTH-1:0] wdata;
    logic [AW-1:0]    raddr;

    // Section k reads k clocks after the scheduler issued the index.
    if (k == 0) begin : g_addr0
      assign raddr = rd_tid;
    end else begin : g_addrk
      assign raddr = tap_tid[k-1];
    end

    always_comb begin
      if (clearing) begin
        we    = 1'b1;
        waddr = clr_addr;
        wdata = '0;
      end else begin
        we    = wr_valid & ready & wr_en[k];
        waddr = wr_tid;
        wdata = wr_data[k*WIDTH +: WIDTH];
      end
    end

    hps_mem_section #(.DEPTH(THREADS), .AW(AW), .WIDTH(WIDTH)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (out_data[k*WIDTH +: WIDTH])
    );

    assign out_tid[k*AW +: AW] = tap_tid[k];
  end

  AST_OUT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) |-> ready); // R7

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> (int'(rd_tid) < THREADS)); // R8

endmodule

// File: tb/tb_hps_state_store.sv
module tb_hps_state_store;
  localparam int CLK_PERIOD = 10;
  localparam int TH  = 6;
  localparam int SEC = 3;
  localparam int W   = 8;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_tid = '0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_tid = '0;
  logic [SEC-1:0] wr_en = '0;
  logic [SEC*W-1:0] wr_data = '0;
  logic [SEC-1:0] out_valid;
  logic [SEC*AW-1:0] out_tid;
  logic [SEC*W-1:0] out_data;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model [TH][SEC];
  int seq [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  hps_state_store #(.THREADS(TH), .SECTIONS(SEC), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .ready(ready),
    .rd_valid(rd_valid), .rd_tid(rd_tid),
    .wr_valid(wr_valid), .wr_tid(wr_tid), .wr_en(wr_en), .wr_data(wr_data),
    .out_valid(out_valid), .out_tid(out_tid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < TH; t++)
      for (int k = 0; k < SEC; k++) model[t][k] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_valid = 1'b0; wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic do_write(input int tid, input logic [SEC-1:0] en, input logic [SEC*W-1:0] data);
    @(negedge clk);
    wr_valid = 1'b1; wr_tid = AW'(tid); wr_en = en; wr_data = data;
    for (int k = 0; k < SEC; k++)
      if (en[k]) model[tid][k] = data[k*W +: W];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Issues seq[0..n-1] back to back and checks each section's skewed output.
  task automatic read_burst(input int n, input string req);
    for (int c = 0; c < n + SEC + 1; c++) begin
      @(negedge clk);
      for (int k = 0; k < SEC; k++) begin
        int j = c - k - 1;
        if (j >= 0 && j < n) begin
          check(out_valid[k] == 1'b1, req, 64'(out_valid[k]), 64'd1);
          check(out_tid[k*AW +: AW] == AW'(seq[j]), req, 64'(out_tid[k*AW +: AW]), 64'(seq[j]));
          check(out_data[k*W +: W] == model[seq[j]][k], req, 64'(out_data[k*W +: W]), 64'(model[seq[j]][k]));
        end else begin
          check(out_valid[k] == 1'b0, req, 64'(out_valid[k]), 64'd0);
        end
      end
      if (c < n) begin
        rd_valid = 1'b1; rd_tid = AW'(seq[c]);
      end else begin
        rd_valid = 1'b0;
      end
    end
  endtask

  // R1 and R2: clear duration and zero contents.
  task automatic t_reset_clear();
    int cycles = 0;
    do_reset();
    while (!ready && cycles < 100) begin
      @(negedge clk);
      cycles++;
      if (cycles == TH - 1)
        check(ready == 1'b0, "R1 ready low during clear", 64'(ready), 64'd0);
    end
    check(cycles == TH, "R1 clear length", 64'(cycles), 64'(TH));
    for (int t = 0; t < TH; t++) seq[t] = t;
    read_burst(TH, "R2 zero after clear");
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready sticky", 64'(ready), 64'd1);
  endtask

  // R4 and R3: full writes then skewed reads.
  task automatic t_write_read();
    for (int t = 0; t < TH; t++)
      do_write(t, '1, {8'(8'h30 + t), 8'(8'h20 + t), 8'(8'h10 + t)});
    for (int t = 0; t < TH; t++) seq[t] = TH - 1 - t;
    read_burst(TH, "R4 R3 write then read");
  endtask

  // R5: masked sections keep their state.
  task automatic t_hold();
    do_write(2, 3'b010, 24'hAA_BB_CC);
    do_write(4, 3'b101, 24'h11_22_33);
    seq[0] = 2; seq[1] = 4; seq[2] = 2;
    read_burst(3, "R5 masked hold");
  endtask

  // R6: same-edge read and write of one entry.
  task automatic t_rdw();
    logic [W-1:0] old0;
    do_write(1, '1, 24'h55_66_77);
    old0 = model[1][0];
    @(negedge clk);
    rd_valid = 1'b1; rd_tid = 3'd1;
    wr_valid = 1'b1; wr_tid = 3'd1; wr_en = '1; wr_data = 24'h9A_8B_7C;
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
    for (int k = 0; k < SEC; k++) model[1][k] = wr_data[k*W +: W];
    check(out_valid[0] && out_data[W-1:0] == old0, "R6 old data on same edge", 64'(out_data[W-1:0]), 64'(old0));
    for (int k = 1; k < SEC; k++) begin
      @(negedge clk);
      check(out_valid[k] && out_data[k*W +: W] == model[1][k], "R6 new data later section",
            64'(out_data[k*W +: W]), 64'(model[1][k]));
    end
    repeat (2) @(negedge clk);
  endtask

  // R8: random back-to-back orders.
  task automatic t_random_order();
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 12; i++) seq[i] = int'($urandom_range(TH - 1, 0));
      read_burst(12, "R8 random order");
      do_write(int'($urandom_range(TH - 1, 0)), 3'($urandom_range(7, 1)), 24'($urandom));
    end
  endtask

  // R7: traffic during the clear walk is ignored.
  task automatic t_ignore_during_clear();
    do_reset();
    rd_valid = 1'b1; rd_tid = 3'd2;
    wr_valid = 1'b1; wr_tid = 3'd2; wr_en = '1; wr_data = 24'hFF_FF_FF;
    for (int c = 0; c < TH - 1; c++) begin
      @(negedge clk);
      check(out_valid == '0, "R7 no valid while clearing", 64'(out_valid), 64'd0);
    end
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
    check(ready == 1'b1, "R7 ready after clear", 64'(ready), 64'd1);
    repeat (2) @(negedge clk);
    seq[0] = 2;
    read_burst(1, "R7 write during clear ignored");
  endtask

  initial begin
    t_reset_clear();
    t_write_read();
    t_hold();
    t_rdw();
    t_random_order();
    t_ignore_during_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule